// File: doc/BRIEF.md
# Two-Bank Clock Register Space

This block holds the 128-byte register space of a real-time clock and decodes every access into it. The low offsets hold the timekeeping and control bytes, then a run of general-purpose RAM. One bit of control register A selects which bank the upper half of the space shows. In bank 0 the upper half is more general RAM. In bank 1 it holds an extended register group: the century byte, the alarm date, two extended control bytes, and an address/data pair that reaches a separate extended RAM indirectly. The counting of time is handled outside this block. The block only stores the bytes and exposes the read-only status inputs at their fixed bit positions.

A host presents one access per cycle on `req_i` with `we_i`, `addr_i` and `wdata_i`. A write takes effect at the edge that accepts it. A read is captured at the accepting edge and is returned on `rdata_o`, with `rvalid_o` high, during the following cycle. An access state machine tracks this with two states. `ST_IDLE` means no read response is pending. `ST_RESP` means a read response is on the outputs. The transitions are:
- idle-to-resp on an accepted read;
- resp-to-resp on a read accepted while a response is shown;
- resp-to-idle and idle-to-idle on a write or on no request.

Top module: `rtcmap_top`

## Requirements
- R1: After reset, `rvalid_o` and `rdata_o` are 0, bank 0 is selected, and every stored byte (clock, control, general RAM, extended registers and extended RAM) reads 0.
- R2: A read accepted at a clock edge drives `rvalid_o` high and its data on `rdata_o` for exactly the next cycle. A write, or a cycle with no request, leaves `rvalid_o` low in the next cycle.
- R3: Offsets 0x00 to 0x09 and 0x0B read back the last byte written to them, in either bank.
- R4: At offset 0x0A, bits 6:0 are writable. Bit 7 reads as `uip_i` sampled at the accepting edge, and writes to bit 7 are ignored.
- R5: Offset 0x0C reads `{flags_i, 4'b0000}` and offset 0x0D reads `{vrt_i, 7'b0}`. Writes to either offset are ignored.
- R6: The bank is bit 4 of offset 0x0A (0 selects bank 0, 1 selects bank 1). A write changing it applies from the very next accepted access.
- R7: Offsets 0x0E to 0x3F are the same general RAM bytes in both banks.
- R8: In bank 0, offsets 0x40 to 0x7F are general RAM. Writes made while bank 1 is selected never change them.
- R9: In bank 1, the century byte is at 0x48, the alarm date at 0x49, and extended control B at 0x4B, all fully read/write. Extended control A is at 0x4A, with bits 6:0 writable and bit 7 reading `vrt_i`.
- R10: In bank 1, offset 0x4C is the read/write extended address byte. Offset 0x4D reads and writes the extended RAM byte at that address. The extended RAM is separate from the general RAM.
- R11: In bank 1, offsets 0x40 to 0x47 and 0x4E to 0x7F read 0 and ignore writes.
- R12: The extended address does not change on data accesses, so consecutive accesses at 0x4D reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte offset in the register space |
| wdata_i | input | 8 | Write data |
| uip_i | input | 1 | Update-in-progress status from the counting logic |
| vrt_i | input | 1 | Valid RAM and time status |
| flags_i | input | 4 | Interrupt flags shown in bits 7:4 of offset 0x0C |
| rdata_o | output | 8 | Read data, valid while rvalid_o is high |
| rvalid_o | output | 1 | Read response strobe |

## Verification
Two things can fall in the same cycle: a write to register A that flips the bank, and the access accepted right after it that lands in the upper half. The bench issues them as back-to-back requests, keeping `req_i` high over both edges. It expects the second access to decode with the new bank. In the same way, a read response can be on the outputs in the cycle that accepts the next request. Back-to-back reads sample the first result in that overlapping cycle and compare both results against a bench model of the map.

// File: rtl/rtcmap_pkg.sv
package rtcmap_pkg;

    // fixed layout of the low clock/control area
    localparam int CLK_COUNT = 14;
    localparam int OFF_CTLA  = 10;
    localparam int OFF_CTLC  = 12;
    localparam int OFF_CTLD  = 13;
    localparam int BANK_BIT  = 4;

    // extended group offsets, relative to the start of the upper half
    localparam int XOFF_CENT  = 8;
    localparam int XOFF_ADATE = 9;
    localparam int XOFF_XCA   = 10;
    localparam int XOFF_XCB   = 11;
    localparam int XOFF_XADDR = 12;
    localparam int XOFF_XDATA = 13;

    typedef enum logic [3:0] {
        RG_CLOCK,
        RG_CTLA,
        RG_CTLC,
        RG_CTLD,
        RG_GRAM,
        RG_CENT,
        RG_ADATE,
        RG_XCA,
        RG_XCB,
        RG_XADDR,
        RG_XDATA,
        RG_NONE
    } region_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } acc_state_t;

endpackage

// File: rtl/rtcmap_decode.sv
module rtcmap_decode
    import rtcmap_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int GIDX_W = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bank_i,
    output region_t           region_o,
    output logic [GIDX_W-1:0] gidx_o
);

    localparam int SPACE = 1 << ADDR_W;
    localparam int HALF  = SPACE / 2;

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] goff;

    always_comb begin
        rel  = addr_i - ADDR_W'(HALF);
        goff = addr_i - ADDR_W'(CLK_COUNT);
        gidx_o = GIDX_W'(goff);
        if (addr_i < ADDR_W'(CLK_COUNT)) begin
            if (addr_i == ADDR_W'(OFF_CTLA))      region_o = RG_CTLA;
            else if (addr_i == ADDR_W'(OFF_CTLC)) region_o = RG_CTLC;
            else if (addr_i == ADDR_W'(OFF_CTLD)) region_o = RG_CTLD;
            else                                  region_o = RG_CLOCK;
        end else if (!bank_i || addr_i < ADDR_W'(HALF)) begin
            region_o = RG_GRAM;
        end else begin
            unique case (rel)
                ADDR_W'(XOFF_CENT):  region_o = RG_CENT;
                ADDR_W'(XOFF_ADATE): region_o = RG_ADATE;
                ADDR_W'(XOFF_XCA):   region_o = RG_XCA;
                ADDR_W'(XOFF_XCB):   region_o = RG_XCB;
                ADDR_W'(XOFF_XADDR): region_o = RG_XADDR;
                ADDR_W'(XOFF_XDATA): region_o = RG_XDATA;
                default:             region_o = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/rtcmap_bram.sv
module rtcmap_bram #(
    parameter int DEPTH  = 114,
    parameter int DATA_W = 8,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i && (int'(idx_i) < DEPTH)) begin
            mem[idx_i] <= wdata_i;
        end
    end

    always_comb begin
        if (int'(idx_i) < DEPTH) rdata_o = mem[idx_i];
        else                     rdata_o = '0;
    end

endmodule

// File: rtl/rtcmap_clkregs.sv
module rtcmap_clkregs
    import rtcmap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CIDX_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              bank_o
);

    logic [DATA_W-1:0] regs [CLK_COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CLK_COUNT; i++) regs[i] <= '0;
        end else if (we_i && (int'(idx_i) < CLK_COUNT)) begin
            if (idx_i == CIDX_W'(OFF_CTLA))
                regs[idx_i] <= {1'b0, wdata_i[DATA_W-2:0]};
            else
                regs[idx_i] <= wdata_i;
        end
    end

    always_comb begin
        if (int'(idx_i) < CLK_COUNT) rdata_o = regs[idx_i];
        else                         rdata_o = '0;
        bank_o = regs[OFF_CTLA][BANK_BIT];
    end

endmodule

// File: rtl/rtcmap_top.sv
module rtcmap_top
    import rtcmap_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 8,
    parameter int XADDR_W = 8,
    parameter int FLAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              uip_i,
    input  logic              vrt_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    localparam int SPACE      = 1 << ADDR_W;
    localparam int GRAM_DEPTH = SPACE - CLK_COUNT;
    localparam int GIDX_W     = $clog2(GRAM_DEPTH);
    localparam int CIDX_W     = $clog2(CLK_COUNT);
    localparam int XDEPTH     = 1 << XADDR_W;

    acc_state_t state, state_nx;
    region_t    region;
    logic                  bank;
    logic [GIDX_W-1:0]     gidx;
    logic [DATA_W-1:0]     clk_rd, gram_rd, xram_rd, rd_mux, rdata_q;
    logic [DATA_W-1:0]     cent_q, adate_q, xca_q, xcb_q;
    logic [XADDR_W-1:0]    xaddr_q;
    logic                  wr, rd, clk_we, gram_we, xram_we;

    assign wr = req_i && we_i;
    assign rd = req_i && !we_i;

    rtcmap_decode #(.ADDR_W(ADDR_W), .GIDX_W(GIDX_W)) u_dec (
        .addr_i  (addr_i),
        .bank_i  (bank),
        .region_o(region),
        .gidx_o  (gidx)
    );

    always_comb begin
        clk_we  = wr && (region == RG_CLOCK || region == RG_CTLA);
        gram_we = wr && (region == RG_GRAM);
        xram_we = wr && (region == RG_XDATA);
    end

    rtcmap_clkregs #(.DATA_W(DATA_W), .CIDX_W(CIDX_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (clk_we),
        .idx_i  (addr_i[CIDX_W-1:0]),
        .wdata_i(wdata_i),
        .rdata_o(clk_rd),
        .bank_o (bank)
    );

    rtcmap_bram #(.DEPTH(GRAM_DEPTH), .DATA_W(DATA_W), .IDX_W(GIDX_W)) u_gram (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (gram_we),
        .idx_i  (gidx),
        .wdata_i(wdata_i),
        .rdata_o(gram_rd)
    );

    rtcmap_bram #(.DEPTH(XDEPTH), .DATA_W(DATA_W), .IDX_W(XADDR_W)) u_xram (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (xram_we),
        .idx_i  (xaddr_q),
        .wdata_i(wdata_i),
        .rdata_o(xram_rd)
    );

    // extended register group of bank 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cent_q  <= '0;
            adate_q <= '0;
            xca_q   <= '0;
            xcb_q   <= '0;
            xaddr_q <= '0;
        end else if (wr) begin
            unique case (region)
                RG_CENT:  cent_q  <= wdata_i;
                RG_ADATE: adate_q <= wdata_i;
                RG_XCA:   xca_q   <= {1'b0, wdata_i[DATA_W-2:0]};
                RG_XCB:   xcb_q   <= wdata_i;
                RG_XADDR: xaddr_q <= XADDR_W'(wdata_i);
                default:  ;
            endcase
        end
    end

    // read selection with read-only bits merged in
    always_comb begin
        unique case (region)
            RG_CLOCK: rd_mux = clk_rd;
            RG_CTLA:  rd_mux = {uip_i, clk_rd[DATA_W-2:0]};
            RG_CTLC:  rd_mux = {flags_i, {(DATA_W-FLAG_W){1'b0}}};
            RG_CTLD:  rd_mux = {vrt_i, {(DATA_W-1){1'b0}}};
            RG_GRAM:  rd_mux = gram_rd;
            RG_CENT:  rd_mux = cent_q;
            RG_ADATE: rd_mux = adate_q;
            RG_XCA:   rd_mux = {vrt_i, xca_q[DATA_W-2:0]};
            RG_XCB:   rd_mux = xcb_q;
            RG_XADDR: rd_mux = DATA_W'(xaddr_q);
            RG_XDATA: rd_mux = xram_rd;
            default:  rd_mux = '0;
        endcase
    end

    // access state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = rd ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // captured read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_mux;
    end

    // outputs
    always_comb begin
        rvalid_o = (state == ST_RESP);
        rdata_o  = rdata_q;
    end

endmodule

// File: rtl/rtcmap_chk.sv
module rtcmap_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wbank_i,
    input logic              uip_i,
    input logic              vrt_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic              bank_q
);

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i) |=> rvalid_o);

    // R2
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !we_i) |=> !rvalid_o);

    // R4
    uip_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i == ADDR_W'(10)) |=> (rdata_o[DATA_W-1] == $past(uip_i)));

    // R5
    vrt_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i == ADDR_W'(13)) |=> (rdata_o == {$past(vrt_i), {(DATA_W-1){1'b0}}}));

    // R6
    bank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && addr_i == ADDR_W'(10)) |=> (bank_q == $past(wbank_i)));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && we_i && addr_i == ADDR_W'(10)) |=> $stable(bank_q));

    // R11
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && bank_q && addr_i >= ADDR_W'(64) && addr_i < ADDR_W'(72)) |=> (rdata_o == '0));

endmodule

bind rtcmap_top rtcmap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wbank_i (wdata_i[4]),
    .uip_i   (uip_i),
    .vrt_i   (vrt_i),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o),
    .bank_q  (bank)
);

// File: tb/sim_rtcmap_top.sv
module sim_rtcmap_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0, we_i = 1'b0, uip_i = 1'b0, vrt_i = 1'b0;
    logic [6:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [3:0] flags_i = '0;
    logic [7:0] rdata_o;
    logic       rvalid_o;

    always #5 clk = ~clk;

    rtcmap_top u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .uip_i(uip_i), .vrt_i(vrt_i), .flags_i(flags_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // bench model of the map
    logic [7:0] m_clk  [16];
    logic [7:0] m_gram [128];
    logic [7:0] m_xram [256];
    logic [7:0] m_cent, m_adate, m_xca, m_xcb, m_xaddr;

    function automatic logic m_bank();
        return m_clk[10][4];
    endfunction

    function automatic string tag_of(logic [6:0] a);
        if (a == 7'h0A) return "R4";
        if (a == 7'h0C || a == 7'h0D) return "R5";
        if (a < 7'h0E) return "R3";
        if (a < 7'h40) return "R7";
        if (!m_bank()) return "R8";
        if (a >= 7'h48 && a <= 7'h4B) return "R9";
        if (a == 7'h4C) return "R10";
        if (a == 7'h4D) return "R10 R12";
        return "R11";
    endfunction

    function automatic logic [7:0] exp_read(logic [6:0] a);
        if (a == 7'h0A) return {uip_i, m_clk[10][6:0]};
        if (a == 7'h0C) return {flags_i, 4'b0000};
        if (a == 7'h0D) return {vrt_i, 7'b0};
        if (a < 7'h0E) return m_clk[a[3:0]];
        if (a < 7'h40 || !m_bank()) return m_gram[a];
        case (a)
            7'h48: return m_cent;
            7'h49: return m_adate;
            7'h4A: return {vrt_i, m_xca[6:0]};
            7'h4B: return m_xcb;
            7'h4C: return m_xaddr;
            7'h4D: return m_xram[m_xaddr];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(logic [6:0] a, logic [7:0] d);
        if (a == 7'h0A) m_clk[10] = {1'b0, d[6:0]};
        else if (a == 7'h0C || a == 7'h0D) ;
        else if (a < 7'h0E) m_clk[a[3:0]] = d;
        else if (a < 7'h40 || !m_bank()) m_gram[a] = d;
        else begin
            case (a)
                7'h48: m_cent = d;
                7'h49: m_adate = d;
                7'h4A: m_xca = {1'b0, d[6:0]};
                7'h4B: m_xcb = d;
                7'h4C: m_xaddr = d;
                7'h4D: m_xram[m_xaddr] = d;
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // two accesses on consecutive edges; the first result is sampled in the
    // cycle that accepts the second
    task automatic do_pair(bit w1, logic [6:0] a1, logic [7:0] d1,
                           bit w2, logic [6:0] a2, logic [7:0] d2);
        logic [7:0] e1, e2;
        string t1, t2;
        @(negedge clk);
        req_i = 1'b1; we_i = w1; addr_i = a1; wdata_i = d1;
        t1 = tag_of(a1);
        e1 = exp_read(a1);
        if (w1) model_write(a1, d1);
        @(negedge clk);
        if (w1) check("R2 write", {7'b0, rvalid_o}, 8'h00);
        else begin
            check("R2 valid", {7'b0, rvalid_o}, 8'h01);
            check(t1, rdata_o, e1);
        end
        we_i = w2; addr_i = a2; wdata_i = d2;
        t2 = tag_of(a2);
        if (w1 && a1 == 7'h0A && a2 >= 7'h40) t2 = {"R6 ", t2};
        e2 = exp_read(a2);
        if (w2) model_write(a2, d2);
        @(negedge clk);
        req_i = 1'b0;
        if (w2) check("R2 write", {7'b0, rvalid_o}, 8'h00);
        else begin
            check("R2 valid", {7'b0, rvalid_o}, 8'h01);
            check(t2, rdata_o, e2);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [7:0] d);
        do_pair(1'b1, a, d, 1'b0, a, 8'h00);
    endtask

    task automatic rd2(logic [6:0] a, logic [6:0] b);
        do_pair(1'b0, a, 8'h00, 1'b0, b, 8'h00);
    endtask

    function automatic logic [6:0] pick_addr();
        case ($urandom % 8)
            0: return 7'h0A;
            1: return 7'h4C;
            2: return 7'h4D;
            3: return 7'(7'h40 + ($urandom % 64));
            4: return 7'(7'h0E + ($urandom % 50));
            5: return 7'($urandom % 14);
            default: return 7'($urandom % 128);
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m_clk[i] = '0;
        for (int i = 0; i < 128; i++) m_gram[i] = '0;
        for (int i = 0; i < 256; i++) m_xram[i] = '0;
        m_cent = '0; m_adate = '0; m_xca = '0; m_xcb = '0; m_xaddr = '0;

        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1 rvalid", {7'b0, rvalid_o}, 8'h00);
        check("R1 rdata", rdata_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rvalid", {7'b0, rvalid_o}, 8'h00);
        rd2(7'h00, 7'h0B);
        rd2(7'h45, 7'h7F);
        rd2(7'h0A, 7'h20);

        // R4: read-only update flag
        wr(7'h0A, 8'hEF);
        uip_i = 1'b1; rd2(7'h0A, 7'h0A);
        uip_i = 1'b0; rd2(7'h0A, 7'h0A);
        wr(7'h0A, 8'h00);

        // R5: read-only C and D
        flags_i = 4'hA; vrt_i = 1'b1;
        wr(7'h0C, 8'hFF); wr(7'h0D, 8'h55);
        rd2(7'h0C, 7'h0D);
        flags_i = 4'h5; vrt_i = 1'b0;
        rd2(7'h0C, 7'h0D);

        // R3, R7, R8 in bank 0
        wr(7'h03, 8'h59); wr(7'h0B, 8'h86);
        wr(7'h20, 8'h3C); wr(7'h48, 8'h11); wr(7'h7F, 8'hE7);

        // R6: bank switch followed at once by an upper access
        do_pair(1'b1, 7'h0A, 8'h10, 1'b1, 7'h48, 8'h22);
        rd2(7'h48, 7'h20);
        rd2(7'h03, 7'h0B);
        wr(7'h49, 8'h31); wr(7'h4A, 8'hFF); wr(7'h4B, 8'hC3);
        vrt_i = 1'b1; rd2(7'h4A, 7'h4B);
        vrt_i = 1'b0; rd2(7'h4A, 7'h49);

        // R10, R12: indirect extended RAM
        wr(7'h4C, 8'h05); wr(7'h4D, 8'hA5);
        wr(7'h4C, 8'h06); wr(7'h4D, 8'h5A);
        wr(7'h4C, 8'h05); rd2(7'h4D, 7'h4D);
        rd2(7'h4C, 7'h4D);

        // R11: holes in bank 1
        wr(7'h40, 8'hFF); wr(7'h47, 8'h77); wr(7'h4E, 8'h99); wr(7'h7F, 8'h12);
        rd2(7'h40, 7'h7F);

        // R8: back to bank 0, contents untouched by bank 1 writes
        do_pair(1'b1, 7'h0A, 8'h00, 1'b0, 7'h48, 8'h00);
        rd2(7'h7F, 7'h4D);

        // constrained random mix
        for (int n = 0; n < 700; n++) begin
            logic [6:0] a1, a2;
            logic [7:0] d1, d2;
            bit w1, w2;
            a1 = pick_addr(); a2 = pick_addr();
            w1 = ($urandom % 2) == 0; w2 = ($urandom % 2) == 0;
            d1 = 8'($urandom); d2 = 8'($urandom);
            if (a1 == 7'h4C) d1 = 8'($urandom % 8);
            if (a2 == 7'h4C) d2 = 8'($urandom % 8);
            uip_i = 1'($urandom); vrt_i = 1'($urandom); flags_i = 4'($urandom);
            do_pair(w1, a1, d1, w2, a2, d2);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule